// File: doc/BRIEF.md
# Cached DRAM Command Decoder

This block sits at the control edge of a cached DRAM and turns the pins sampled on each rising clock edge into commands. The pins are an active-low chip select, an active-low next-cycle clock mask for the DRAM side and another for the SRAM side, the three active-low controls RAS#, CAS# and a transfer-direction bit, and a 12-bit multiplexed address. Each decoded command comes out as a registered single-cycle strobe. The address fields that go with a command are latched beside it: the row number for an activation, the block number and transfer opcode for a column cycle, the command word for a register-load cycle, and the raw control bits for any other combination.

The decoder keeps a flag that records whether a row has been opened. A column cycle that arrives while no row is open is rejected with an illegal-command strobe. Either clock mask taken low turns off the matching internal clock for the following cycle. While the DRAM side is gated no DRAM command is decoded. While the SRAM side is gated the SRAM read-data output is frozen.

Top module: `cdram_cmd_decoder`

## Requirements
- R1: The strobes are registered: a command sampled at a rising edge shows on its strobe for exactly the following cycle, and at most one of the nine strobes is high in any cycle.
- R2: With chip select low and RAS# low, CAS# high, direction high, the activate strobe fires, the 12-bit address is latched as the row number, and the row-active flag goes high.
- R3: With chip select low, RAS# high and CAS# low while a row is active, a read-transfer strobe fires if direction is high and a write-transfer strobe fires if direction is low. Address bits 7..3 are latched as the block number and bits 2..0 as the transfer opcode.
- R4: A column cycle while no row is active raises only the illegal strobe, issues no transfer strobe, and leaves the block number and opcode unchanged.
- R5: With chip select low and RAS#, CAS# and direction all low, the set-command strobe fires and address bits 9..0 are latched as the command word.
- R6: Any other control combination with chip select low raises the other-command strobe and latches {RAS#, CAS#, direction} as a 3-bit value.
- R7: Chip select high gives the no-operation strobe only when the SRAM mask sampled at the previous edge was high. Otherwise it gives no strobe at all.
- R8: DRAM mask low at an edge gives the DRAM power-down strobe and takes priority over every other decode at that edge. In the next cycle no DRAM command, no-operation or other/illegal strobe is decoded; only the SRAM power-down strobe can fire then.
- R9: SRAM mask low at an edge (with the DRAM side not gated and its mask high) gives the SRAM power-down strobe and discards the command at that edge. In the following cycle the SRAM data output keeps its value. In every other cycle it registers the SRAM data input.
- R10: Synchronous active-high reset clears all strobes, the row-active flag, both gating states and every latched field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Chip select, active low |
| dMaskN | input | 1 | DRAM clock mask, low gates next cycle |
| sMaskN | input | 1 | SRAM clock mask, low gates next cycle |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| dtdN | input | 1 | Transfer direction, low = buffer to array |
| addr | input | 12 | Multiplexed address |
| sramIn | input | 16 | SRAM read data from the cache |
| actStb | output | 1 | Activate strobe |
| rdXferStb | output | 1 | Array-to-read-buffer transfer strobe |
| wrXferStb | output | 1 | Write-buffer-to-array transfer strobe |
| setCmdStb | output | 1 | Command-register load strobe |
| nopStb | output | 1 | No-operation strobe |
| dramPdStb | output | 1 | DRAM power-down strobe |
| sramPdStb | output | 1 | SRAM power-down strobe |
| otherStb | output | 1 | Other-command strobe |
| illegalStb | output | 1 | Column cycle without an open row |
| rowActive | output | 1 | A row has been activated |
| rowAddr | output | 12 | Latched row number |
| blockAddr | output | 5 | Latched block number |
| xferOp | output | 3 | Latched transfer opcode |
| cmdWord | output | 10 | Latched command word |
| ctlBits | output | 3 | Latched {RAS#, CAS#, direction} of the last other command |
| sramOut | output | 16 | SRAM data output, held while the SRAM side is gated |

## Verification
The assertions assume that reset is held high at the first clock edges, so that $past of the row flag and of the gating state is defined when they are first checked. They also assume that every control pin has a 0 or 1 value at each edge, because an unknown pin would be sent to the other-command path. The bench drives every input on the falling edge from tables and tasks, with reset high in its first vector, so all pins are known well before each rising edge.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef struct packed {
    logic act;
    logic rdX;
    logic wrX;
    logic setCmd;
    logic nop;
    logic dPd;
    logic sPd;
    logic other;
    logic illegal;
  } strobe_t;

  typedef struct packed {
    logic ldRow;
    logic ldCol;
    logic ldCmd;
    logic ldCtl;
    logic holdSram;
  } dpCtl_t;

  localparam int ADDR_W_DEF = 12;
  localparam int BLK_LSB_DEF = 3;
  localparam int BLK_W_DEF = 5;
  localparam int OP_W_DEF = 3;
  localparam int CMD_W_DEF = 10;
  localparam int DATA_W_DEF = 16;
endpackage

// File: rtl/cdram_ctrl.sv
module cdram_ctrl
  import cdram_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    csN,
  input  logic    dMaskN,
  input  logic    sMaskN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    dtdN,
  output strobe_t strb,
  output dpCtl_t  dp,
  output logic    rowActive
);
  strobe_t nxt;
  logic dGated;
  logic sGated;

  always_comb begin
    nxt = '0;
    dp = '0;
    dp.holdSram = sGated;
    if (dGated) begin
      if (!sMaskN) nxt.sPd = 1'b1;
    end else if (!dMaskN) begin
      nxt.dPd = 1'b1;
    end else if (!sMaskN) begin
      nxt.sPd = 1'b1;
    end else if (csN) begin
      if (!sGated) nxt.nop = 1'b1;
    end else if (!rasN && casN && dtdN) begin
      nxt.act = 1'b1;
      dp.ldRow = 1'b1;
    end else if (rasN && !casN) begin
      if (rowActive) begin
        dp.ldCol = 1'b1;
        if (dtdN) nxt.rdX = 1'b1;
        else nxt.wrX = 1'b1;
      end else begin
        nxt.illegal = 1'b1;
      end
    end else if (!rasN && !casN && !dtdN) begin
      nxt.setCmd = 1'b1;
      dp.ldCmd = 1'b1;
    end else begin
      nxt.other = 1'b1;
      dp.ldCtl = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= '0;
      rowActive <= 1'b0;
      dGated <= 1'b0;
      sGated <= 1'b0;
    end else begin
      strb <= nxt;
      dGated <= !dMaskN;
      sGated <= !sMaskN;
      if (nxt.act) rowActive <= 1'b1;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(strb))
    else $error("more than one strobe high");
  p_xfer_row_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.rdX || strb.wrX) |-> $past(rowActive))
    else $error("transfer without open row");
  p_illegal_norow_r4: assert property (@(posedge clk) disable iff (rst)
    strb.illegal |-> !$past(rowActive))
    else $error("illegal flagged with open row");
  p_nop_mask_r7: assert property (@(posedge clk) disable iff (rst)
    strb.nop |-> ($past(csN) && !$past(sGated)))
    else $error("nop without its conditions");
  p_gated_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    dGated |=> !(strb.act || strb.rdX || strb.wrX || strb.setCmd ||
                 strb.nop || strb.dPd || strb.other || strb.illegal))
    else $error("DRAM command while gated");
endmodule

// File: rtl/cdram_dpath.sv
module cdram_dpath
  import cdram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int BLK_LSB = BLK_LSB_DEF,
  parameter int BLK_W = BLK_W_DEF,
  parameter int OP_W = OP_W_DEF,
  parameter int CMD_W = CMD_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dp,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rasN,
  input  logic              casN,
  input  logic              dtdN,
  input  logic [DATA_W-1:0] sramIn,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [BLK_W-1:0]  blockAddr,
  output logic [OP_W-1:0]   xferOp,
  output logic [CMD_W-1:0]  cmdWord,
  output logic [2:0]        ctlBits,
  output logic [DATA_W-1:0] sramOut
);
  localparam int BLK_MSB = BLK_LSB + BLK_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rowAddr <= '0;
      blockAddr <= '0;
      xferOp <= '0;
      cmdWord <= '0;
      ctlBits <= '0;
      sramOut <= '0;
    end else begin
      if (dp.ldRow) rowAddr <= addr;
      if (dp.ldCol) begin
        blockAddr <= addr[BLK_MSB:BLK_LSB];
        xferOp <= addr[OP_W-1:0];
      end
      if (dp.ldCmd) cmdWord <= addr[CMD_W-1:0];
      if (dp.ldCtl) ctlBits <= {rasN, casN, dtdN};
      if (!dp.holdSram) sramOut <= sramIn;
    end
  end

  p_row_latch_r2: assert property (@(posedge clk) disable iff (rst)
    dp.ldRow |=> rowAddr == $past(addr))
    else $error("row not latched");
  p_cmd_latch_r5: assert property (@(posedge clk) disable iff (rst)
    dp.ldCmd |=> cmdWord == $past(addr[CMD_W-1:0]))
    else $error("command word not latched");
  p_sram_hold_r9: assert property (@(posedge clk) disable iff (rst)
    dp.holdSram |=> $stable(sramOut))
    else $error("SRAM data changed while gated");
endmodule

// File: rtl/cdram_cmd_decoder.sv
module cdram_cmd_decoder
  import cdram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int BLK_LSB = BLK_LSB_DEF,
  parameter int BLK_W = BLK_W_DEF,
  parameter int OP_W = OP_W_DEF,
  parameter int CMD_W = CMD_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              dMaskN,
  input  logic              sMaskN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              dtdN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] sramIn,
  output logic              actStb,
  output logic              rdXferStb,
  output logic              wrXferStb,
  output logic              setCmdStb,
  output logic              nopStb,
  output logic              dramPdStb,
  output logic              sramPdStb,
  output logic              otherStb,
  output logic              illegalStb,
  output logic              rowActive,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [BLK_W-1:0]  blockAddr,
  output logic [OP_W-1:0]   xferOp,
  output logic [CMD_W-1:0]  cmdWord,
  output logic [2:0]        ctlBits,
  output logic [DATA_W-1:0] sramOut
);
  strobe_t strb;
  dpCtl_t dp;

  cdram_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .dMaskN(dMaskN), .sMaskN(sMaskN),
    .rasN(rasN), .casN(casN), .dtdN(dtdN),
    .strb(strb), .dp(dp), .rowActive(rowActive)
  );

  cdram_dpath #(
    .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BLK_W(BLK_W),
    .OP_W(OP_W), .CMD_W(CMD_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .dp(dp), .addr(addr),
    .rasN(rasN), .casN(casN), .dtdN(dtdN), .sramIn(sramIn),
    .rowAddr(rowAddr), .blockAddr(blockAddr), .xferOp(xferOp),
    .cmdWord(cmdWord), .ctlBits(ctlBits), .sramOut(sramOut)
  );

  assign actStb = strb.act;
  assign rdXferStb = strb.rdX;
  assign wrXferStb = strb.wrX;
  assign setCmdStb = strb.setCmd;
  assign nopStb = strb.nop;
  assign dramPdStb = strb.dPd;
  assign sramPdStb = strb.sPd;
  assign otherStb = strb.other;
  assign illegalStb = strb.illegal;
endmodule

// File: tb/sim_cdram_cmd_decoder.sv
module sim_cdram_cmd_decoder;
  logic clk = 1'b0;
  logic rst, csN, dMaskN, sMaskN, rasN, casN, dtdN;
  logic [11:0] addr;
  logic [15:0] sramIn;
  logic actStb, rdXferStb, wrXferStb, setCmdStb, nopStb;
  logic dramPdStb, sramPdStb, otherStb, illegalStb, rowActive;
  logic [11:0] rowAddr;
  logic [4:0] blockAddr;
  logic [2:0] xferOp;
  logic [9:0] cmdWord;
  logic [2:0] ctlBits;
  logic [15:0] sramOut;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  cdram_cmd_decoder u0 (
    .clk(clk), .rst(rst), .csN(csN), .dMaskN(dMaskN), .sMaskN(sMaskN),
    .rasN(rasN), .casN(casN), .dtdN(dtdN), .addr(addr), .sramIn(sramIn),
    .actStb(actStb), .rdXferStb(rdXferStb), .wrXferStb(wrXferStb),
    .setCmdStb(setCmdStb), .nopStb(nopStb), .dramPdStb(dramPdStb),
    .sramPdStb(sramPdStb), .otherStb(otherStb), .illegalStb(illegalStb),
    .rowActive(rowActive), .rowAddr(rowAddr), .blockAddr(blockAddr),
    .xferOp(xferOp), .cmdWord(cmdWord), .ctlBits(ctlBits), .sramOut(sramOut)
  );

  // strobe order: act rdX wrX setCmd nop dPd sPd other illegal
  wire [8:0] strbOut = {actStb, rdXferStb, wrXferStb, setCmdStb, nopStb,
                        dramPdStb, sramPdStb, otherStb, illegalStb};

  typedef struct packed {
    logic rst, cs, dm, sm, ras, cas, dtd;
    logic [11:0] addr;
    logic [15:0] sin;
    logic [8:0] strb;
    logic [11:0] row;
    logic [4:0] blk;
    logic [2:0] op;
    logic [9:0] cmd;
    logic [2:0] ctl;
    logic [15:0] sout;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1,0,1,1,1,1,1,12'h000,16'h1111, 9'h000,12'h000,5'h00,3'd0,10'h000,3'd0,16'h0000},
    '{0,0,1,1,1,0,1,12'h0D5,16'h1001, 9'h001,12'h000,5'h00,3'd0,10'h000,3'd0,16'h1001},
    '{0,0,1,1,0,1,1,12'hABC,16'h1002, 9'h100,12'hABC,5'h00,3'd0,10'h000,3'd0,16'h1002},
    '{0,0,1,1,1,0,1,12'h0D5,16'h1003, 9'h080,12'hABC,5'h1A,3'd5,10'h000,3'd0,16'h1003},
    '{0,0,1,1,1,0,0,12'h0FA,16'h1004, 9'h040,12'hABC,5'h1F,3'd2,10'h000,3'd0,16'h1004},
    '{0,0,1,1,0,0,0,12'hF3C,16'h1005, 9'h020,12'hABC,5'h1F,3'd2,10'h33C,3'd0,16'h1005},
    '{0,0,1,1,1,1,1,12'h000,16'h1006, 9'h002,12'hABC,5'h1F,3'd2,10'h33C,3'd7,16'h1006},
    '{0,0,1,1,0,1,0,12'h000,16'h1007, 9'h002,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h1007},
    '{0,1,1,1,1,1,1,12'h000,16'h1008, 9'h010,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h1008},
    '{0,0,1,0,0,1,1,12'h555,16'h1009, 9'h004,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h1009},
    '{0,1,1,1,1,1,1,12'h000,16'h100A, 9'h000,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h1009},
    '{0,1,1,1,1,1,1,12'h000,16'h100B, 9'h010,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h100B},
    '{0,0,0,1,0,1,1,12'h777,16'h100C, 9'h008,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h100C},
    '{0,0,1,0,0,1,1,12'h777,16'h100D, 9'h004,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h100D},
    '{0,0,0,0,0,1,1,12'h321,16'h100E, 9'h008,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h100D},
    '{0,0,1,1,0,1,1,12'h123,16'h100F, 9'h000,12'hABC,5'h1F,3'd2,10'h33C,3'd2,16'h100D},
    '{0,0,1,1,0,1,1,12'h123,16'h1010, 9'h100,12'h123,5'h1F,3'd2,10'h33C,3'd2,16'h1010},
    '{0,0,1,1,1,0,1,12'h000,16'h1011, 9'h080,12'h123,5'h00,3'd0,10'h33C,3'd2,16'h1011},
    '{1,0,1,1,1,1,1,12'h000,16'h1012, 9'h000,12'h000,5'h00,3'd0,10'h000,3'd0,16'h0000},
    '{0,0,1,1,1,0,0,12'h0FA,16'h1013, 9'h001,12'h000,5'h00,3'd0,10'h000,3'd0,16'h1013},
    '{0,1,1,1,0,0,0,12'hF3C,16'h1014, 9'h010,12'h000,5'h00,3'd0,10'h000,3'd0,16'h1014}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic r, input logic cs, input logic dm, input logic sm,
                       input logic ra, input logic ca, input logic dt,
                       input logic [11:0] ad, input logic [15:0] si);
    rst = r; csN = cs; dMaskN = dm; sMaskN = sm;
    rasN = ra; casN = ca; dtdN = dt; addr = ad; sramIn = si;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 1, 1, 1, 1, 1, 12'h000, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].rst, TBL[i].cs, TBL[i].dm, TBL[i].sm, TBL[i].ras, TBL[i].cas,
            TBL[i].dtd, TBL[i].addr, TBL[i].sin);
      check($sformatf("R1 strobes vec %0d", i), 32'(strbOut), 32'(TBL[i].strb));
      check($sformatf("R2 rowAddr vec %0d", i), 32'(rowAddr), 32'(TBL[i].row));
      check($sformatf("R3 blockAddr vec %0d", i), 32'(blockAddr), 32'(TBL[i].blk));
      check($sformatf("R3 xferOp vec %0d", i), 32'(xferOp), 32'(TBL[i].op));
      check($sformatf("R5 cmdWord vec %0d", i), 32'(cmdWord), 32'(TBL[i].cmd));
      check($sformatf("R6 ctlBits vec %0d", i), 32'(ctlBits), 32'(TBL[i].ctl));
      check($sformatf("R9 sramOut vec %0d", i), 32'(sramOut), 32'(TBL[i].sout));
    end

    // R7: chip select high right after an SRAM mask gives nothing, then a nop
    drive(0, 0, 1, 0, 1, 1, 1, 12'h000, 16'h2000);
    check("R9 sram power-down", 32'(strbOut), 32'h004);
    drive(0, 1, 1, 1, 1, 1, 1, 12'h000, 16'h2001);
    check("R7 no nop after SRAM mask", 32'(strbOut), 32'h000);
    check("R9 sramOut held", 32'(sramOut), 32'h2000);
    drive(0, 1, 1, 1, 0, 1, 1, 12'hFFF, 16'h2002);
    check("R7 nop ignores controls", 32'(strbOut), 32'h010);
    check("R7 row untouched by deselect", 32'(rowAddr), 32'h000);

    // R4: column with no open row
    drive(0, 0, 1, 1, 1, 0, 1, 12'h0FF, 16'h2003);
    check("R4 illegal strobe", 32'(strbOut), 32'h001);
    check("R4 block unchanged", 32'(blockAddr), 32'h00);
    check("R4 opcode unchanged", 32'(xferOp), 32'h0);
    check("R4 row still closed", 32'(rowActive), 32'h0);

    // R8: DRAM mask blocks the next activation
    drive(0, 0, 0, 1, 0, 1, 1, 12'h9F0, 16'h2004);
    check("R8 dram power-down", 32'(strbOut), 32'h008);
    drive(0, 0, 1, 1, 0, 1, 1, 12'h9F0, 16'h2005);
    check("R8 gated activate dropped", 32'(strbOut), 32'h000);
    check("R8 row flag unchanged", 32'(rowActive), 32'h0);
    drive(0, 0, 1, 1, 0, 1, 1, 12'h9F0, 16'h2006);
    check("R2 activate after gating", 32'(strbOut), 32'h100);
    check("R2 row flag set", 32'(rowActive), 32'h1);
    check("R2 row latched", 32'(rowAddr), 32'h9F0);

    // R10: reset with an activation on the pins
    drive(1, 0, 1, 1, 0, 1, 1, 12'h456, 16'h2007);
    check("R10 strobes cleared", 32'(strbOut), 32'h000);
    check("R10 row flag cleared", 32'(rowActive), 32'h0);
    check("R10 row cleared", 32'(rowAddr), 32'h000);
    check("R10 sram cleared", 32'(sramOut), 32'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule